// File: doc/BRIEF.md
# Two-Bank Interrupt Collector with Mixed Trigger Types

This block collects 64 synchronous interrupt lines into two 32-bit banks and drives a single interrupt request to a processor. Each bit of a bank is either edge-type or level-type, and that choice is fixed by parameters at build time. An edge-type bit latches a pending event on a rising edge of its line, and the event stays latched until software clears it. A level-type bit never latches. It requests service only while its line is high.

Software sees each bank as four 32-bit words inside a 4 KB window on a one-cycle register bus. The words are the latched events, an enable mask, a write-one-to-clear word and the live line levels. The processor request is high whenever any enabled bit in either bank has a latched event or is a level-type bit whose line is high.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset, the events, mask and levels words of both banks read zero, `cpu_irq` is low and `bus_rdata` is zero.
- R2: Line n goes to bank (1 - n[5]) at bit n[4:0]. Lines 32..63 therefore fill bank 0 and lines 0..31 fill bank 1. Bank 0 sits at addresses 0x010..0x01F and bank 1 at 0x020..0x02F.
- R3: Within a bank, offset 0xC returns the line levels sampled at the previous clock edge.
- R4: An edge-type bit sets its event on a rising edge of its line, which is a line high where the sampled level was low. The event stays set after the line falls. A line held high does not set the event again after it is cleared.
- R5: Level-type bits are bank 1 bits 20..28 by default, and there are none in bank 0. They never show in the events word (offset 0x0) and are unaffected by clear writes. They request an interrupt while their line is high and the bit is enabled.
- R6: A write to offset 0x8 clears each event bit whose write-data bit is 1. Bits written as 0 keep their value.
- R7: If a rising edge and a clear hit the same event bit in the same cycle, the bit ends up set.
- R8: `cpu_irq` is high one cycle after some bank has a bit set in ((events | (levels & level_type)) & mask). Otherwise it is low.
- R9: Offset 0x4 is the read/write enable mask of the bank.
- R10: Addresses outside 0x010..0x02F, and offsets other than 0x0, 0x4, 0x8 and 0xC, ignore writes and read zero. The clear offset 0x8 also reads zero.
- R11: Read data appears on `bus_rdata` in the cycle after a read request and is zero in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Interrupt lines, synchronous to clk |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| cpu_irq | output | 1 | Registered interrupt request to the processor |

## Verification
A change on a line reaches the levels and events words at the next clock edge, and `cpu_irq` follows one edge later, so the output is due two edges after the stimulus. A register write takes effect at its edge and moves `cpu_irq` one edge after that. The read driver queues each expected word tagged with the cycle in which its data is due, one edge after the request. The monitor compares a queued word only on that cycle, sampling at the falling clock edge. Checks on `cpu_irq` wait for the two-edge or one-edge delay before they sample.

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl #(
  parameter int          DW       = 32,
  parameter int          AW       = 12,
  parameter logic [31:0] LVL_CFG0 = 32'h0000_0000,
  parameter logic [31:0] LVL_CFG1 = 32'h1FF0_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*DW-1:0] irq_in,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            cpu_irq
);
  localparam int NB = 2;

  logic [DW-1:0] ev [NB];
  logic [DW-1:0] mk [NB];
  logic [DW-1:0] lv [NB];
  logic [DW-1:0] cfg [NB];
  logic [DW-1:0] in_b [NB];
  logic [DW-1:0] rise [NB];
  logic [DW-1:0] clr [NB];
  logic [DW-1:0] pend [NB];
  logic [DW-1:0] rd_val;

  logic       hit, sel, wr, rd;
  logic [3:0] off;

  assign in_b[0] = irq_in[2*DW-1:DW];
  assign in_b[1] = irq_in[DW-1:0];
  assign cfg[0]  = LVL_CFG0[DW-1:0];
  assign cfg[1]  = LVL_CFG1[DW-1:0];

  assign hit = (bus_addr[AW-1:4] == 1) || (bus_addr[AW-1:4] == 2);
  assign sel = bus_addr[5];
  assign off = bus_addr[3:0];
  assign wr  = bus_valid && bus_write && hit;
  assign rd  = bus_valid && !bus_write && hit;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign rise[b] = in_b[b] & ~lv[b] & ~cfg[b];
    assign clr[b]  = (wr && sel == b[0] && off == 4'h8) ? (bus_wdata & ~cfg[b]) : '0;
    assign pend[b] = (ev[b] | (lv[b] & cfg[b])) & mk[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        ev[b] <= '0;
        mk[b] <= '0;
        lv[b] <= '0;
      end
    end else begin
      for (int b = 0; b < NB; b++) begin
        lv[b] <= in_b[b];
        ev[b] <= (ev[b] & ~clr[b]) | rise[b];
        if (wr && sel == b[0] && off == 4'h4) mk[b] <= bus_wdata;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (rd) begin
      case (off)
        4'h0:    rd_val = sel ? ev[1] : ev[0];
        4'h4:    rd_val = sel ? mk[1] : mk[0];
        4'hC:    rd_val = sel ? lv[1] : lv[0];
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      cpu_irq   <= 1'b0;
    end else begin
      bus_rdata <= rd_val;
      cpu_irq   <= (|pend[0]) || (|pend[1]);
    end
  end

  assert_levels_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> lv[1] == $past(irq_in[DW-1:0]));

  assert_event_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr[0] == '0 |=> (ev[0] & $past(ev[0])) == $past(ev[0]));

  assert_no_level_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == 12'h020) |=> (bus_rdata & LVL_CFG1[DW-1:0]) == '0);

  assert_clear_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == 12'h018)
      |=> (ev[0] & $past(bus_wdata) & ~$past(rise[0])) == '0);

  assert_enabled_event_raises_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[1] & mk[1]) != '0 |=> cpu_irq);

  assert_outside_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && !hit) |=> bus_rdata == '0);

  assert_idle_rdata_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> bus_rdata == '0);
endmodule

// File: tb/tb_irq_bank_ctrl.sv
module tb_irq_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_irq;

  irq_bank_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [31:0] exp;
    int          due;
    string       tag;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      n_run++;
      if (bus_rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s: rdata=%h expected=%h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.due = cyc + 1; it.tag = tag;
    sb.push_back(it);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    n_run++;
    if (cpu_irq !== e) begin
      n_fail++;
      $display("FAIL %s: cpu_irq=%b expected=%b", tag, cpu_irq, e);
    end
  endtask

  task automatic chk_rdata_idle(input string tag);
    n_run++;
    if (bus_rdata !== 32'h0) begin
      n_fail++;
      $display("FAIL %s: idle rdata=%h expected=00000000", tag, bus_rdata);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    chk_rdata_idle("R1 rdata after reset");
    bus_rd(12'h010, 32'h0, "R1 bank0 events");
    bus_rd(12'h014, 32'h0, "R1 bank0 mask");
    bus_rd(12'h02C, 32'h0, "R1 bank1 levels");
    // R9 mask read/write
    bus_wr(12'h014, 32'h0000_0002);
    bus_wr(12'h024, 32'h0010_0001);
    bus_rd(12'h014, 32'h0000_0002, "R9 bank0 mask");
    bus_rd(12'h024, 32'h0010_0001, "R9 bank1 mask");
    // R2 / R4 line 0 lands in bank1 bit0
    irq_in[0] = 1'b1;
    idle(1);
    bus_rd(12'h020, 32'h1, "R2 line0 to bank1");
    chk_irq(1'b1, "R8 enabled event raises irq");
    bus_rd(12'h010, 32'h0, "R2 bank0 untouched");
    irq_in[0] = 1'b0;
    idle(2);
    bus_rd(12'h020, 32'h1, "R4 event sticky after fall");
    bus_rd(12'h02C, 32'h0, "R3 level follows fall");
    chk_irq(1'b1, "R8 irq held by latched event");
    // R6 clear
    bus_wr(12'h028, 32'hFFFF_FFFE);
    bus_rd(12'h020, 32'h1, "R6 zero bit keeps event");
    bus_wr(12'h028, 32'h0000_0001);
    bus_rd(12'h020, 32'h0, "R6 one bit clears event");
    chk_irq(1'b0, "R8 irq low after clear");
    // R3 levels, masked-off events
    irq_in[35] = 1'b1; irq_in[5] = 1'b1;
    idle(1);
    bus_rd(12'h01C, 32'h0000_0008, "R3 bank0 levels");
    bus_rd(12'h02C, 32'h0000_0020, "R3 bank1 levels");
    bus_rd(12'h010, 32'h0000_0008, "R2 line35 to bank0 bit3");
    chk_irq(1'b0, "R8 masked events keep irq low");
    // R4 held high, no relatch
    bus_wr(12'h018, 32'h0000_0008);
    idle(3);
    bus_rd(12'h010, 32'h0, "R4 held line no relatch");
    irq_in[35] = 1'b0; irq_in[5] = 1'b0;
    bus_wr(12'h028, 32'hFFFF_FFFF);
    bus_rd(12'h020, 32'h0, "R6 bank1 all cleared");
    // R5 level-type bit 20 of bank1
    irq_in[20] = 1'b1;
    idle(1);
    bus_rd(12'h020, 32'h0, "R5 level bit no event");
    bus_rd(12'h02C, 32'h0010_0000, "R5 level visible");
    chk_irq(1'b1, "R5 level bit raises irq");
    bus_wr(12'h028, 32'h0010_0000);
    idle(1);
    chk_irq(1'b1, "R5 clear ignores level bit");
    irq_in[20] = 1'b0;
    idle(2);
    chk_irq(1'b0, "R5 irq follows level fall");
    irq_in[21] = 1'b1;
    idle(2);
    chk_irq(1'b0, "R5 unmasked level bit ignored");
    irq_in[21] = 1'b0;
    idle(2);
    // R7 set wins over clear
    irq_in[33] = 1'b1;
    bus_wr(12'h018, 32'h0000_0002);
    bus_rd(12'h010, 32'h0000_0002, "R7 set beats clear");
    chk_irq(1'b1, "R7 irq from bank0 event");
    irq_in[33] = 1'b0;
    bus_wr(12'h018, 32'h0000_0002);
    bus_rd(12'h010, 32'h0, "R6 bank0 cleared");
    // R10 decode
    bus_wr(12'h034, 32'hFFFF_FFFF);
    bus_wr(12'h004, 32'hFFFF_FFFF);
    bus_wr(12'h114, 32'hFFFF_FFFF);
    bus_wr(12'h015, 32'hFFFF_FFFF);
    bus_rd(12'h014, 32'h0000_0002, "R10 stray writes ignored");
    bus_rd(12'h034, 32'h0, "R10 outside window reads zero");
    bus_rd(12'h000, 32'h0, "R10 below window reads zero");
    bus_rd(12'h018, 32'h0, "R10 clear offset reads zero");
    bus_rd(12'h011, 32'h0, "R10 undefined offset reads zero");
    // R11 idle rdata
    idle(1);
    chk_rdata_idle("R11 rdata zero without read");
    // R1 reset mid-run
    irq_in[40] = 1'b1;
    idle(2);
    rst_n = 1'b0;
    idle(2);
    irq_in[40] = 1'b0;
    rst_n = 1'b1;
    idle(1);
    chk_irq(1'b0, "R1 irq after second reset");
    bus_rd(12'h014, 32'h0, "R1 mask after second reset");
    bus_rd(12'h010, 32'h0, "R1 events after second reset");
    idle(2);
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R11: %0d reads never compared, expected 0", sb.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule